// File: doc/BRIEF.md
# Translation Table Mapping Update Engine

This block keeps a three-level translation table in memory up to date. The table takes a main-surface address to its auxiliary data. A map command gives a main start address, an auxiliary start address, a byte length and a 16-bit format field. The engine steps through the range one 64 KB main page at a time. For each page it walks from a fixed root table through a middle table to a leaf table, and it writes the leaf entry. An unmap command gives a start address and a length, and it clears the valid bit of every valid leaf in that range.

When a walk for a map command finds that a middle or leaf table is missing, the engine builds that table. It takes space from an internal bump allocator that works over a pool of equal-sized backing regions. It fills the new table with zeros, one 64-bit write at a time, and only then links the table into its parent entry. All table traffic uses one 64-bit memory port. A read request returns its data on the next cycle. When the command ends, the engine pulses a done flag. With the same pulse it raises a flush-required flag if any leaf rewrite could leave cached translations stale, and it raises an error flag if the pool ran out.

Top module: `aux_map_updater`

## Requirements
- R1: After reset and while idle, `busy_o`, `done_o`, `flush_o`, `err_o` and `mem_req_o` are all low.
- R2: A command covers ceil(length / 64 KB) pages. Page k uses main address start + k*64 KB and auxiliary address start + k*256 B. Every memory access is 8-byte aligned.
- R3: For each page, the top entry is read at root + 8*main[47:36]. If its bit 0 is clear on a map command, a 32 KB table aligned to 32 KB is allocated. The top entry is then written as (table address with bits 14:0 cleared) | 1.
- R4: The middle entry is read at middle-table base + 8*main[35:24]. If its bit 0 is clear on a map command, an 8 KB table aligned to 8 KB is allocated. The middle entry is then written as (table address with bits 12:0 cleared) | 1. The leaf entry is at leaf-table base + 8*main[23:16].
- R5: The allocator rounds the current region offset up to the table size. If the rounded request does not fit in the region, the allocator moves to the start of the next region. Region i starts at pool base + i * region size.
- R6: On map, the new leaf is {fmt[15:0] in bits 63:48, aux[47:8] in bits 47:8, bits 7:1 zero, bit 0 = 1}. It is written only if the old leaf has bit 0 clear. A valid old leaf is left unchanged.
- R7: On map, flush is required when the old leaf has bit 0 clear, is non-zero, and (old | 1) differs from the new leaf.
- R8: On unmap, a page whose top or middle entry is invalid is skipped, and nothing is allocated. A valid leaf has only bit 0 cleared. Upper entries are never changed.
- R9: On unmap, flush is required when clearing bit 0 leaves a leaf equal to zero.
- R10: `done_o` is high for exactly one cycle at the end of each command. `flush_o` is high only in that cycle, and at most once per command. A zero-length command finishes with no memory access.
- R11: If a table is needed and no region has room for it, the command aborts without writing. `err_o` is raised together with `done_o`, and the allocator state is left unchanged.
- R12: A new table is zero-filled with consecutive 64-bit writes at ascending addresses before its parent entry is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a command; sampled only while idle |
| unmap_i | input | 1 | 1 = unmap command, 0 = map command |
| main_addr_i | input | 48 | Main start address, aligned to 64 KB |
| aux_addr_i | input | 48 | Auxiliary start address, aligned to 256 B |
| len_i | input | 48 | Length of the range in bytes |
| fmt_i | input | 16 | Format field placed in leaf bits 63:48 |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle pulse when the command ends |
| flush_o | output | 1 | Flush required; valid together with done_o |
| err_o | output | 1 | Pool exhausted, command aborted; valid together with done_o |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 48 | Byte address of the 64-bit word |
| mem_wdata_o | output | 64 | Write data |
| mem_rdata_i | input | 64 | Read data, one cycle after a read request |

## Verification
Some properties are checked on every cycle: the port stays quiet while idle, every access is word-aligned, done is a single-cycle pulse, and flush and error appear only with done. While a table is being zero-filled, each write must fall exactly one word after the previous one. Other behaviour can only be shown by the bench's command sequence. That includes where the allocator places tables, moving to the next region, and aborting when the pool is empty. It also includes the leaf values and the flush decision for each combination of old and new leaf contents. The bench memory returns non-zero garbage for pool words that were never written, so a missing zero-fill shows up as a mismatch in the memory image.

// File: rtl/aux_map_pkg.sv
package aux_map_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_LOOP, S_RD_TOP, S_CHK_TOP, S_RD_MID, S_CHK_MID,
    S_ZERO, S_LINK, S_RD_LEAF, S_CHK_LEAF, S_WR_LEAF, S_STEP, S_FIN
  } walk_state_e;

  // keep bits [hi-1:lo] of a 64-bit word
  function automatic logic [63:0] field_mask(input int unsigned hi, input int unsigned lo);
    logic [63:0] m;
    for (int i = 0; i < 64; i++) m[i] = (i >= lo) && (i < hi);
    return m;
  endfunction
endpackage

// File: rtl/tbl_bump_alloc.sv
module tbl_bump_alloc #(
  parameter int unsigned ADDR_W       = 48,
  parameter logic [47:0] POOL_BASE    = 48'h0000_4000_0000,
  parameter int unsigned REGION_SHIFT = 20,
  parameter int unsigned NUM_REGIONS  = 8,
  parameter int unsigned BIG_SHIFT    = 15,
  parameter int unsigned SMALL_SHIFT  = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              big_i,
  output logic              ok_o,
  output logic [ADDR_W-1:0] base_o
);
  localparam int unsigned OFF_W  = REGION_SHIFT + 2;
  localparam int unsigned RIDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;
  localparam logic [OFF_W-1:0] REG_SZ   = OFF_W'(1) << REGION_SHIFT;
  localparam logic [OFF_W-1:0] BIG_SZ   = OFF_W'(1) << BIG_SHIFT;
  localparam logic [OFF_W-1:0] SMALL_SZ = OFF_W'(1) << SMALL_SHIFT;
  localparam logic [RIDX_W-1:0] LAST_REG = RIDX_W'(NUM_REGIONS - 1);

  logic [OFF_W-1:0]  off_q, sz, padded, end_off;
  logic [RIDX_W-1:0] reg_q;
  logic              fits, has_next;
  logic [ADDR_W-1:0] cur_base, next_base;

  always_comb begin
    sz        = big_i ? BIG_SZ : SMALL_SZ;
    padded    = (off_q + sz - OFF_W'(1)) & ~(sz - OFF_W'(1));
    end_off   = padded + sz;
    fits      = end_off <= REG_SZ;
    has_next  = reg_q != LAST_REG;
    cur_base  = ADDR_W'(POOL_BASE) + (ADDR_W'(reg_q) << REGION_SHIFT);
    next_base = ADDR_W'(POOL_BASE) + ((ADDR_W'(reg_q) + ADDR_W'(1)) << REGION_SHIFT);
    ok_o      = fits || has_next;
    base_o    = fits ? cur_base + ADDR_W'(padded) : next_base;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q <= '0;
      reg_q <= '0;
    end else if (req_i && ok_o) begin
      if (fits) begin
        off_q <= end_off;
      end else begin
        reg_q <= reg_q + RIDX_W'(1);
        off_q <= sz;
      end
    end
  end
endmodule

// File: rtl/tbl_leaf_rule.sv
module tbl_leaf_rule (
  input  logic        unmap_i,
  input  logic [63:0] old_i,
  input  logic [63:0] new_i,
  output logic        we_o,
  output logic [63:0] val_o,
  output logic        flush_o
);
  always_comb begin
    if (unmap_i) begin
      we_o    = old_i[0];
      val_o   = {old_i[63:1], 1'b0};
      flush_o = old_i[0] && (old_i[63:1] == '0);
    end else begin
      we_o    = !old_i[0];
      val_o   = new_i;
      flush_o = !old_i[0] && (old_i != '0) && ((old_i | 64'd1) != new_i);
    end
  end
endmodule

// File: rtl/tbl_walk_ctrl.sv
module tbl_walk_ctrl
  import aux_map_pkg::*;
#(
  parameter int unsigned ADDR_W         = 48,
  parameter int unsigned FMT_W          = 16,
  parameter int unsigned PAGE_SHIFT     = 16,
  parameter int unsigned IDX1_W         = 8,
  parameter int unsigned IDX2_W         = 12,
  parameter int unsigned IDX3_W         = 12,
  parameter int unsigned MID_TBL_SHIFT  = 15,
  parameter int unsigned LEAF_TBL_SHIFT = 13,
  parameter int unsigned LEAF_LO        = 8,
  parameter int unsigned AUX_PAGE_SHIFT = 8,
  parameter logic [47:0] ROOT_ADDR      = 48'h0000_0001_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              unmap_i,
  input  logic [ADDR_W-1:0] main_addr_i,
  input  logic [ADDR_W-1:0] aux_addr_i,
  input  logic [ADDR_W-1:0] len_i,
  input  logic [FMT_W-1:0]  fmt_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              flush_o,
  output logic              err_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [63:0]       mem_wdata_o,
  input  logic [63:0]       mem_rdata_i,
  output logic              alloc_req_o,
  output logic              alloc_big_o,
  input  logic              alloc_ok_i,
  input  logic [ADDR_W-1:0] alloc_base_i,
  output logic              rule_unmap_o,
  output logic [63:0]       rule_new_o,
  input  logic              rule_we_i,
  input  logic [63:0]       rule_val_i,
  input  logic              rule_flush_i
);
  localparam int unsigned L1_LO = PAGE_SHIFT;
  localparam int unsigned L2_LO = L1_LO + IDX1_W;
  localparam int unsigned L3_LO = L2_LO + IDX2_W;
  localparam int unsigned ZP_W  = MID_TBL_SHIFT - 3;
  localparam logic [63:0] TOP_MASK  = field_mask(ADDR_W, MID_TBL_SHIFT);
  localparam logic [63:0] MID_MASK  = field_mask(ADDR_W, LEAF_TBL_SHIFT);
  localparam logic [63:0] AUX_MASK  = field_mask(ADDR_W, LEAF_LO);
  localparam logic [ZP_W-1:0] MID_LAST  = ZP_W'((1 << (MID_TBL_SHIFT - 3)) - 1);
  localparam logic [ZP_W-1:0] LEAF_LAST = ZP_W'((1 << (LEAF_TBL_SHIFT - 3)) - 1);
  localparam logic [ADDR_W:0] PAGE_B = (ADDR_W+1)'(1) << PAGE_SHIFT;

  walk_state_e       state_q;
  logic              unmap_q, flush_q, err_q, lvl_q;
  logic [ADDR_W-1:0] main_q, aux_q, len_q, new_tbl_q, mid_tbl_q, leaf_tbl_q;
  logic [ADDR_W:0]   off_q;
  logic [FMT_W-1:0]  fmt_q;
  logic [ZP_W-1:0]   zptr_q;
  logic [63:0]       leaf_val_q;

  logic [IDX3_W-1:0] top_idx;
  logic [IDX2_W-1:0] mid_idx;
  logic [IDX1_W-1:0] leaf_idx;
  logic [ADDR_W-1:0] top_ea, mid_ea, leaf_ea;
  logic              need_alloc;

  always_comb begin
    top_idx  = main_q[L3_LO +: IDX3_W];
    mid_idx  = main_q[L2_LO +: IDX2_W];
    leaf_idx = main_q[L1_LO +: IDX1_W];
    top_ea   = ADDR_W'(ROOT_ADDR) + ADDR_W'({top_idx, 3'b000});
    mid_ea   = mid_tbl_q + ADDR_W'({mid_idx, 3'b000});
    leaf_ea  = leaf_tbl_q + ADDR_W'({leaf_idx, 3'b000});
    need_alloc = !mem_rdata_i[0] && !unmap_q;
  end

  assign rule_unmap_o = unmap_q;
  assign rule_new_o   = (64'(aux_q) & AUX_MASK) | (64'(fmt_q) << ADDR_W) | 64'd1;
  assign alloc_req_o  = need_alloc && (state_q == S_CHK_TOP || state_q == S_CHK_MID);
  assign alloc_big_o  = state_q == S_CHK_TOP;

  assign busy_o  = state_q != S_IDLE;
  assign done_o  = state_q == S_FIN;
  assign flush_o = done_o && flush_q;
  assign err_o   = done_o && err_q;

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (state_q)
      S_RD_TOP:  begin mem_req_o = 1'b1; mem_addr_o = top_ea; end
      S_RD_MID:  begin mem_req_o = 1'b1; mem_addr_o = mid_ea; end
      S_RD_LEAF: begin mem_req_o = 1'b1; mem_addr_o = leaf_ea; end
      S_ZERO: begin
        mem_req_o  = 1'b1;
        mem_we_o   = 1'b1;
        mem_addr_o = new_tbl_q + ADDR_W'({zptr_q, 3'b000});
      end
      S_LINK: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
        if (!lvl_q) begin
          mem_addr_o  = top_ea;
          mem_wdata_o = (64'(new_tbl_q) & TOP_MASK) | 64'd1;
        end else begin
          mem_addr_o  = mid_ea;
          mem_wdata_o = (64'(new_tbl_q) & MID_MASK) | 64'd1;
        end
      end
      S_WR_LEAF: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = leaf_ea;
        mem_wdata_o = leaf_val_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      unmap_q    <= 1'b0;
      flush_q    <= 1'b0;
      err_q      <= 1'b0;
      lvl_q      <= 1'b0;
      main_q     <= '0;
      aux_q      <= '0;
      len_q      <= '0;
      new_tbl_q  <= '0;
      mid_tbl_q  <= '0;
      leaf_tbl_q <= '0;
      off_q      <= '0;
      fmt_q      <= '0;
      zptr_q     <= '0;
      leaf_val_q <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          unmap_q <= unmap_i;
          main_q  <= main_addr_i;
          aux_q   <= aux_addr_i;
          len_q   <= len_i;
          fmt_q   <= fmt_i;
          off_q   <= '0;
          flush_q <= 1'b0;
          err_q   <= 1'b0;
          state_q <= S_LOOP;
        end
        S_LOOP:   state_q <= (off_q < {1'b0, len_q}) ? S_RD_TOP : S_FIN;
        S_RD_TOP: state_q <= S_CHK_TOP;
        S_CHK_TOP: begin
          if (mem_rdata_i[0]) begin
            mid_tbl_q <= ADDR_W'(mem_rdata_i & TOP_MASK);
            state_q   <= S_RD_MID;
          end else if (unmap_q) begin
            state_q <= S_STEP;
          end else if (!alloc_ok_i) begin
            err_q   <= 1'b1;
            state_q <= S_FIN;
          end else begin
            new_tbl_q <= alloc_base_i;
            zptr_q    <= '0;
            lvl_q     <= 1'b0;
            state_q   <= S_ZERO;
          end
        end
        S_RD_MID: state_q <= S_CHK_MID;
        S_CHK_MID: begin
          if (mem_rdata_i[0]) begin
            leaf_tbl_q <= ADDR_W'(mem_rdata_i & MID_MASK);
            state_q    <= S_RD_LEAF;
          end else if (unmap_q) begin
            state_q <= S_STEP;
          end else if (!alloc_ok_i) begin
            err_q   <= 1'b1;
            state_q <= S_FIN;
          end else begin
            new_tbl_q <= alloc_base_i;
            zptr_q    <= '0;
            lvl_q     <= 1'b1;
            state_q   <= S_ZERO;
          end
        end
        S_ZERO: begin
          zptr_q <= zptr_q + ZP_W'(1);
          if (zptr_q == (lvl_q ? LEAF_LAST : MID_LAST)) state_q <= S_LINK;
        end
        S_LINK: begin
          if (!lvl_q) begin
            mid_tbl_q <= new_tbl_q;
            state_q   <= S_RD_MID;
          end else begin
            leaf_tbl_q <= new_tbl_q;
            state_q    <= S_RD_LEAF;
          end
        end
        S_RD_LEAF: state_q <= S_CHK_LEAF;
        S_CHK_LEAF: begin
          flush_q    <= flush_q | rule_flush_i;
          leaf_val_q <= rule_val_i;
          state_q    <= rule_we_i ? S_WR_LEAF : S_STEP;
        end
        S_WR_LEAF: state_q <= S_STEP;
        S_STEP: begin
          main_q  <= main_q + ADDR_W'(PAGE_B);
          off_q   <= off_q + PAGE_B;
          aux_q   <= aux_q + (ADDR_W'(1) << AUX_PAGE_SHIFT);
          state_q <= S_LOOP;
        end
        S_FIN:   state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/aux_map_updater.sv
module aux_map_updater #(
  parameter int unsigned ADDR_W         = 48,
  parameter int unsigned FMT_W          = 16,
  parameter int unsigned PAGE_SHIFT     = 16,
  parameter int unsigned IDX1_W         = 8,
  parameter int unsigned IDX2_W         = 12,
  parameter int unsigned IDX3_W         = 12,
  parameter int unsigned MID_TBL_SHIFT  = 15,
  parameter int unsigned LEAF_TBL_SHIFT = 13,
  parameter int unsigned LEAF_LO        = 8,
  parameter int unsigned AUX_PAGE_SHIFT = 8,
  parameter logic [47:0] ROOT_ADDR      = 48'h0000_0001_0000,
  parameter logic [47:0] POOL_BASE      = 48'h0000_4000_0000,
  parameter int unsigned REGION_SHIFT   = 20,
  parameter int unsigned NUM_REGIONS    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              unmap_i,
  input  logic [ADDR_W-1:0] main_addr_i,
  input  logic [ADDR_W-1:0] aux_addr_i,
  input  logic [ADDR_W-1:0] len_i,
  input  logic [FMT_W-1:0]  fmt_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              flush_o,
  output logic              err_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [63:0]       mem_wdata_o,
  input  logic [63:0]       mem_rdata_i
);
  logic              alloc_req, alloc_big, alloc_ok;
  logic [ADDR_W-1:0] alloc_base;
  logic              rule_unmap, rule_we, rule_flush;
  logic [63:0]       rule_new, rule_val;

  tbl_walk_ctrl #(
    .ADDR_W(ADDR_W), .FMT_W(FMT_W), .PAGE_SHIFT(PAGE_SHIFT),
    .IDX1_W(IDX1_W), .IDX2_W(IDX2_W), .IDX3_W(IDX3_W),
    .MID_TBL_SHIFT(MID_TBL_SHIFT), .LEAF_TBL_SHIFT(LEAF_TBL_SHIFT),
    .LEAF_LO(LEAF_LO), .AUX_PAGE_SHIFT(AUX_PAGE_SHIFT), .ROOT_ADDR(ROOT_ADDR)
  ) i_walk (
    .clk_i, .rst_ni, .start_i, .unmap_i, .main_addr_i, .aux_addr_i, .len_i, .fmt_i,
    .busy_o, .done_o, .flush_o, .err_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_rdata_i,
    .alloc_req_o(alloc_req), .alloc_big_o(alloc_big),
    .alloc_ok_i(alloc_ok), .alloc_base_i(alloc_base),
    .rule_unmap_o(rule_unmap), .rule_new_o(rule_new),
    .rule_we_i(rule_we), .rule_val_i(rule_val), .rule_flush_i(rule_flush)
  );

  tbl_bump_alloc #(
    .ADDR_W(ADDR_W), .POOL_BASE(POOL_BASE), .REGION_SHIFT(REGION_SHIFT),
    .NUM_REGIONS(NUM_REGIONS), .BIG_SHIFT(MID_TBL_SHIFT), .SMALL_SHIFT(LEAF_TBL_SHIFT)
  ) i_alloc (
    .clk_i, .rst_ni, .req_i(alloc_req), .big_i(alloc_big),
    .ok_o(alloc_ok), .base_o(alloc_base)
  );

  tbl_leaf_rule i_rule (
    .unmap_i(rule_unmap), .old_i(mem_rdata_i), .new_i(rule_new),
    .we_o(rule_we), .val_o(rule_val), .flush_o(rule_flush)
  );
endmodule

// File: rtl/aux_map_updater_chk.sv
module aux_map_updater_chk #(
  parameter int unsigned ADDR_W = 48
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              flush_o,
  input logic              err_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [63:0]       mem_wdata_o
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_req_o && !done_o));

  p_word_aligned_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[2:0] == 3'b000));

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_flush_at_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> done_o);

  p_start_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  p_err_at_done_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

  p_fill_ascending_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && mem_wdata_o == 64'd0 &&
     $past(mem_req_o && mem_we_o && mem_wdata_o == 64'd0))
    |-> (mem_addr_o == $past(mem_addr_o) + ADDR_W'(8)));
endmodule

bind aux_map_updater aux_map_updater_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .flush_o(flush_o), .err_o(err_o), .mem_req_o(mem_req_o),
  .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o)
);

// File: tb/test_aux_map_updater.sv
`timescale 1ns/1ps
module test_aux_map_updater;
  localparam logic [47:0] ROOT = 48'h0000_0001_0000;
  localparam logic [47:0] POOL = 48'h0000_0100_0000;
  localparam longint      RB   = 65536;
  localparam int          NR   = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, unmap = 1'b0;
  logic [47:0] main_a = '0, aux_a = '0, len = '0;
  logic [15:0] fmt = '0;
  logic        busy, done, flush, err, mreq, mwe;
  logic [47:0] maddr;
  logic [63:0] mwdata, mrdata;

  int checks = 0, fails = 0;
  int mreq_cnt = 0;
  logic [63:0] dmem [logic [47:0]];
  logic [63:0] rmem [logic [47:0]];
  int ref_reg = 0;
  longint ref_off = 0;

  always #2.5 clk = ~clk;

  aux_map_updater #(
    .ROOT_ADDR(ROOT), .POOL_BASE(POOL), .REGION_SHIFT(16), .NUM_REGIONS(NR)
  ) i_aux_map_updater (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .unmap_i(unmap),
    .main_addr_i(main_a), .aux_addr_i(aux_a), .len_i(len), .fmt_i(fmt),
    .busy_o(busy), .done_o(done), .flush_o(flush), .err_o(err),
    .mem_req_o(mreq), .mem_we_o(mwe), .mem_addr_o(maddr),
    .mem_wdata_o(mwdata), .mem_rdata_i(mrdata)
  );

  // unwritten pool words read as garbage so a missing zero-fill is visible
  function automatic logic [63:0] dm_rd(input logic [47:0] a);
    if (dmem.exists(a)) return dmem[a];
    if (a >= POOL) return {16'hBAD1, a} ^ 64'h0F0F_0000_0000_0001;
    return 64'd0;
  endfunction

  always @(posedge clk) begin
    if (mreq) begin
      mreq_cnt++;
      if (mwe) dmem[maddr] = mwdata;
      else mrdata <= dm_rd(maddr);
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] r_rd(input logic [47:0] a);
    return rmem.exists(a) ? rmem[a] : 64'd0;
  endfunction

  function automatic bit r_alloc(input longint sz, output logic [47:0] base);
    longint padded = ((ref_off + sz - 1) / sz) * sz;
    if (padded + sz <= RB) begin
      base = POOL + 48'(ref_reg * RB + padded);
      ref_off = padded + sz;
      return 1;
    end
    if (ref_reg + 1 < NR) begin
      ref_reg++;
      base = POOL + 48'(ref_reg * RB);
      ref_off = sz;
      return 1;
    end
    return 0;
  endfunction

  task automatic r_run(input bit um, input logic [47:0] a, input logic [47:0] ax,
                       input logic [47:0] ln, input logic [15:0] f,
                       output bit xf, output bit xe);
    xf = 0; xe = 0;
    for (longint pg = 0; pg * 65536 < longint'(ln); pg++) begin
      logic [47:0] ma, aa, ea2, ea1, ea0, base, t2, t1;
      logic [63:0] e, old, leaf;
      ma = a + 48'(pg * 65536);
      aa = ax + 48'(pg * 256);
      ea2 = ROOT + {33'd0, ma[47:36], 3'b000};
      e = r_rd(ea2);
      if (!e[0]) begin
        if (um) continue;
        if (!r_alloc(32768, base)) begin xe = 1; break; end
        for (int i = 0; i < 4096; i++) rmem[base + 48'(i * 8)] = 64'd0;
        rmem[ea2] = {16'd0, base[47:15], 15'd1};
        e = rmem[ea2];
      end
      t2 = {e[47:15], 15'd0};
      ea1 = t2 + {33'd0, ma[35:24], 3'b000};
      e = r_rd(ea1);
      if (!e[0]) begin
        if (um) continue;
        if (!r_alloc(8192, base)) begin xe = 1; break; end
        for (int i = 0; i < 1024; i++) rmem[base + 48'(i * 8)] = 64'd0;
        rmem[ea1] = {16'd0, base[47:13], 13'd1};
        e = rmem[ea1];
      end
      t1 = {e[47:13], 13'd0};
      ea0 = t1 + {37'd0, ma[23:16], 3'b000};
      old = r_rd(ea0);
      leaf = {f, aa[47:8], 8'h01};
      if (um) begin
        if (old[0]) begin
          rmem[ea0] = {old[63:1], 1'b0};
          if (old[63:1] == 63'd0) xf = 1;
        end
      end else if (!old[0]) begin
        if (old != 64'd0 && (old | 64'd1) != leaf) xf = 1;
        rmem[ea0] = leaf;
      end
    end
  endtask

  task automatic run_cmd(input string req, input bit um, input logic [47:0] a,
                         input logic [47:0] ax, input logic [47:0] ln, input logic [15:0] f);
    bit xf, xe, img_ok;
    int n = 0, q0;
    logic [47:0] bad_a;
    r_run(um, a, ax, ln, f, xf, xe);
    q0 = mreq_cnt;
    unmap = um; main_a = a; aux_a = ax; len = ln; fmt = f; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && n < 30000) begin
      check(!((flush || err) && !done), req, "flag outside done", {62'd0, flush, err}, 64'd0);
      check(busy, req, "busy during command", {63'd0, busy}, 64'd1);
      @(negedge clk);
      n++;
    end
    check(done, req, "command completes", {63'd0, done}, 64'd1);
    check(flush == xf, req, "flush at done", {63'd0, flush}, {63'd0, xf});
    check(err == xe, req, "error at done", {63'd0, err}, {63'd0, xe});
    img_ok = (dmem.num() == rmem.num());
    bad_a = '0;
    foreach (rmem[k]) if (img_ok && dm_rd(k) != rmem[k]) begin img_ok = 0; bad_a = k; end
    check(img_ok, req, "memory image", dm_rd(bad_a), r_rd(bad_a));
    if (ln == 48'd0)
      check(mreq_cnt == q0 && n == 1, "R10", "zero length: accesses/cycles",
            64'(mreq_cnt - q0), 64'd0);
    @(negedge clk);
    check(!done && !flush && !busy, "R10", "done is one cycle",
          {61'd0, done, flush, busy}, 64'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy, "R1", "busy after reset", {63'd0, busy}, 64'd0);
    check(!done, "R1", "done after reset", {63'd0, done}, 64'd0);
    check(!flush, "R1", "flush after reset", {63'd0, flush}, 64'd0);
    check(!err, "R1", "err after reset", {63'd0, err}, 64'd0);
    check(!mreq, "R1", "mem_req after reset", {63'd0, mreq}, 64'd0);
    // R2 R3 R4 R6 R12: three pages, new middle and leaf tables, format field
    run_cmd("R2 R3 R4 R6 R12", 0, 48'h0010_0200_0000, 48'h0000_8000_0000, 48'h3_0000, 16'hA5C3);
    // R8: unmap one valid leaf, bit 0 only
    run_cmd("R8 R9", 1, 48'h0010_0200_0000, 48'h0, 48'h1_0000, 16'h0);
    // R7: remap stale leaf with different aux -> flush
    run_cmd("R7", 0, 48'h0010_0200_0000, 48'h0000_9000_0000, 48'h1_0000, 16'hA5C3);
    // R6: valid leaf is not overwritten
    run_cmd("R6", 0, 48'h0010_0201_0000, 48'h0000_7700_0000, 48'h1_0000, 16'h1234);
    // R8: unmap under invalid top entry allocates nothing
    run_cmd("R8", 1, 48'h0070_0000_0000, 48'h0, 48'h2_0000, 16'h0);
    // R4 R5: crosses a middle index, two new leaf tables
    run_cmd("R4 R5", 0, 48'h0010_03FF_0000, 48'h0000_A000_0000, 48'h2_0000, 16'h0042);
    // R5: middle table does not fit, rolls into next region
    run_cmd("R5", 0, 48'h0020_0000_0000, 48'h0000_B000_0000, 48'h1_0000, 16'h0007);
    // R11: pool exhausted
    run_cmd("R11", 0, 48'h0030_0000_0000, 48'h0000_C000_0000, 48'h1_0000, 16'h0007);
    // R9: leaf that is only the valid bit
    run_cmd("R9", 0, 48'h0010_0205_0000, 48'h0, 48'h1_0000, 16'h0);
    run_cmd("R9", 1, 48'h0010_0205_0000, 48'h0, 48'h1_0000, 16'h0);
    // R10: zero length
    run_cmd("R10", 0, 48'h0010_0206_0000, 48'h0, 48'h0, 16'h0);
    // R9 R10: two zeroing leaves in one command, single flush
    run_cmd("R9", 0, 48'h0010_0206_0000, 48'h0, 48'h1_0000, 16'h0);
    run_cmd("R9", 0, 48'h0010_0207_0000, 48'h0, 48'h1_0000, 16'h0);
    run_cmd("R9 R10", 1, 48'h0010_0205_0000, 48'h0, 48'h3_0000, 16'h0);
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule